// File: doc/BRIEF.md
# Generated-Code Instruction Feeder

This block sits on a 6507-style cartridge bus and answers every instruction fetch with machine code that it makes up on the spot. It does not look anything up in a stored program. A producer queues register-write requests, each naming a zero-page hardware register and a byte, and the feeder hands the CPU an immediate accumulator load of that byte followed by a zero-page store to that register. A request flagged as a line-sync asks for a single store to the horizontal-sync strobe instead. When nothing is queued, the CPU is kept busy with one-byte no-operation filler.

The feeder counts the cycles of each instruction it has emitted, so it always knows whether the CPU's next read is an opcode, an operand, a discarded dummy read or a write. The CPU program counter climbs as the emitted code runs. Whenever an opcode fetch lands at or beyond a configurable offset near the top of the cartridge window, the feeder emits an absolute jump back to the window base. The answer byte is a combinational function of the presented address and the held state, so it is ready within the same bus cycle. The CPU is assumed to start on an opcode fetch at the window base when reset is released.

Top module: `instruction_feeder`

## Requirements
- R1: After reset, with an empty queue, the first opcode fetch returns 0xEA, the block drives the bus for it, and `req_ready` is low.
- R2: A request with `req_sync` low is emitted over five cycles: opcode 0xA9, the request value, opcode 0x85, the request register address, and then the CPU store cycle. The register therefore receives exactly the requested value.
- R3: A request with `req_sync` high is emitted as opcode 0x85 followed by operand 0x02, the horizontal-sync strobe address. No load precedes it.
- R4: With no request pending, an opcode fetch returns 0xEA (no operation). The following dummy read also returns 0xEA and is not consumed as an instruction, so the next cycle is again an opcode fetch.
- R5: An opcode fetch whose offset inside the window (address bits 11:0) is at least `JMP_AT` returns 0x4C, then 0x00, then 0x10, which is an absolute jump to 0x1000. This takes priority over any request. A store still owed after a load is emitted after the jump.
- R6: `req_ready` is high only in the cycle in which the store's operand byte is presented, so each store consumes one request. Requests are emitted in queue order.
- R7: `cpu_doe` is high only for reads (`cpu_rw` high) with address bit 12 high, and never during the CPU's store cycle. `cpu_dout` is 0 whenever `cpu_doe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU bus cycle clock, one edge per bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 13 | CPU address; bit 12 selects the cartridge window |
| cpu_rw | input | 1 | High for a read cycle, low for a write cycle |
| cpu_dout | output | 8 | Byte presented to the CPU |
| cpu_doe | output | 1 | Data bus drive enable |
| req_valid | input | 1 | Head of the request queue is valid |
| req_sync | input | 1 | Head request is a horizontal-sync store |
| req_reg | input | 8 | Zero-page register address of the head request |
| req_val | input | 8 | Value to write for the head request |
| req_ready | output | 1 | Head request consumed at this clock edge |

## Verification
The bench plays the CPU itself. It decodes each byte it is given, steps its own program counter and logs every store, and it predicts each opcode from its own view of the queue and the counter. The queue is swept through all 64 low register addresses and through all 256 values into one register. These sweeps separate an operand swap or a stale-value bug from a correct load/store pair. A mixed queue of line-syncs and writes shows whether a sync is wrongly preceded by a load or pops the wrong entry. A small jump threshold forces many wraps, and one wrap is placed deliberately between a load and its store to show that the owed store survives the jump. Stray reads and writes are made outside the window and to the window, and each must leave the bus undriven.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

    localparam logic [7:0] OPC_LDA_IMM = 8'hA9;
    localparam logic [7:0] OPC_STA_ZP  = 8'h85;
    localparam logic [7:0] OPC_NOP     = 8'hEA;
    localparam logic [7:0] OPC_JMP_ABS = 8'h4C;
    localparam logic [7:0] HSYNC_ZP    = 8'h02;

    // Which bus cycle of the current instruction comes next
    typedef enum logic [2:0] {
        PH_OPC,    // opcode fetch
        PH_ARG1,   // first operand byte
        PH_ARG2,   // second operand byte (jump high byte)
        PH_STORE,  // CPU write cycle of a zero-page store
        PH_SKIP    // dummy read following a one-byte opcode
    } phase_t;

    typedef enum logic [1:0] {
        INS_NOP,
        INS_LDA,
        INS_STA,
        INS_JMP
    } ins_t;

    typedef struct packed {
        phase_t phase;
        ins_t   ins;
        logic   sta_due;   // load emitted, store for the head request owed
    } seq_t;

endpackage

// File: rtl/fdr_pick.sv
// Chooses the instruction to emit at an opcode fetch.
module fdr_pick
    import feeder_pkg::*;
(
    input  logic near_top,
    input  logic sta_due,
    input  logic req_valid,
    input  logic req_sync,
    output ins_t choice
);

    always_comb begin
        if (near_top) begin
            choice = INS_JMP;
        end else if (sta_due) begin
            choice = INS_STA;
        end else if (req_valid) begin
            choice = req_sync ? INS_STA : INS_LDA;
        end else begin
            choice = INS_NOP;
        end
    end

endmodule

// File: rtl/fdr_seq.sv
// Tracks the CPU bus cycle within the instruction being emitted.
module fdr_seq
    import feeder_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ins_t   choice,
    output phase_t phase,
    output ins_t   ins,
    output logic   sta_due,
    output logic   pop
);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        pop   = 1'b0;
        unique case (seq_q.phase)
            PH_OPC: begin
                seq_d.ins   = choice;
                seq_d.phase = (choice == INS_NOP) ? PH_SKIP : PH_ARG1;
            end
            PH_ARG1: begin
                unique case (seq_q.ins)
                    INS_LDA: begin
                        seq_d.phase   = PH_OPC;
                        seq_d.sta_due = 1'b1;
                    end
                    INS_STA: begin
                        seq_d.phase   = PH_STORE;
                        seq_d.sta_due = 1'b0;
                        pop           = 1'b1;
                    end
                    INS_JMP: seq_d.phase = PH_ARG2;
                    default: seq_d.phase = PH_OPC;
                endcase
            end
            PH_ARG2:  seq_d.phase = PH_OPC;
            PH_STORE: seq_d.phase = PH_OPC;
            PH_SKIP:  seq_d.phase = PH_OPC;
            default:  seq_d.phase = PH_OPC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_OPC, ins: INS_NOP, sta_due: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase   = seq_q.phase;
    assign ins     = seq_q.ins;
    assign sta_due = seq_q.sta_due;

endmodule

// File: rtl/fdr_emit.sv
// Forms the byte for the current bus cycle and gates the bus drive.
module fdr_emit
    import feeder_pkg::*;
#(
    parameter logic [15:0] JMP_TARGET = 16'h1000
) (
    input  phase_t     phase,
    input  ins_t       ins,
    input  ins_t       choice,
    input  logic       sta_due,
    input  logic [7:0] req_reg,
    input  logic [7:0] req_val,
    input  logic       win_sel,
    input  logic       cpu_rw,
    output logic [7:0] cpu_dout,
    output logic       cpu_doe
);

    localparam logic [7:0] TGT_LO = JMP_TARGET[7:0];
    localparam logic [7:0] TGT_HI = JMP_TARGET[15:8];

    logic [7:0] byte_d;

    function automatic logic [7:0] opcode_of(input ins_t i);
        unique case (i)
            INS_LDA: opcode_of = OPC_LDA_IMM;
            INS_STA: opcode_of = OPC_STA_ZP;
            INS_JMP: opcode_of = OPC_JMP_ABS;
            default: opcode_of = OPC_NOP;
        endcase
    endfunction

    always_comb begin
        unique case (phase)
            PH_OPC:  byte_d = opcode_of(choice);
            PH_ARG1: begin
                unique case (ins)
                    INS_LDA: byte_d = req_val;
                    INS_STA: byte_d = sta_due ? req_reg : HSYNC_ZP;
                    INS_JMP: byte_d = TGT_LO;
                    default: byte_d = OPC_NOP;
                endcase
            end
            PH_ARG2: byte_d = TGT_HI;
            PH_SKIP: byte_d = OPC_NOP;
            default: byte_d = 8'h00;
        endcase
    end

    assign cpu_doe  = cpu_rw && win_sel && (phase != PH_STORE);
    assign cpu_dout = cpu_doe ? byte_d : 8'h00;

endmodule

// File: rtl/instruction_feeder.sv
module instruction_feeder
    import feeder_pkg::*;
#(
    parameter int                  ADDR_W     = 13,
    parameter logic [ADDR_W-2:0]   JMP_AT     = 'hFF0,
    parameter logic [15:0]         JMP_TARGET = 16'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    output logic [7:0]        cpu_dout,
    output logic              cpu_doe,
    input  logic              req_valid,
    input  logic              req_sync,
    input  logic [7:0]        req_reg,
    input  logic [7:0]        req_val,
    output logic              req_ready
);

    localparam int WIN_BIT = ADDR_W - 1;

    phase_t phase;
    ins_t   ins;
    ins_t   choice;
    logic   sta_due;
    logic   near_top;
    logic   at_opc;

    assign near_top = (cpu_addr[WIN_BIT-1:0] >= JMP_AT);
    assign at_opc   = (phase == PH_OPC);

    fdr_pick u_pick (
        .near_top  (near_top),
        .sta_due   (sta_due),
        .req_valid (req_valid),
        .req_sync  (req_sync),
        .choice    (choice)
    );

    fdr_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .choice  (choice),
        .phase   (phase),
        .ins     (ins),
        .sta_due (sta_due),
        .pop     (req_ready)
    );

    fdr_emit #(
        .JMP_TARGET (JMP_TARGET)
    ) u_emit (
        .phase    (phase),
        .ins      (ins),
        .choice   (choice),
        .sta_due  (sta_due),
        .req_reg  (req_reg),
        .req_val  (req_val),
        .win_sel  (cpu_addr[WIN_BIT]),
        .cpu_rw   (cpu_rw),
        .cpu_dout (cpu_dout),
        .cpu_doe  (cpu_doe)
    );

endmodule

// File: rtl/feeder_chk.sv
module feeder_chk
    import feeder_pkg::*;
#(
    parameter int                ADDR_W     = 13,
    parameter logic [ADDR_W-2:0] JMP_AT     = 'hFF0,
    parameter logic [15:0]       JMP_TARGET = 16'h1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rw,
    input logic [7:0]        cpu_dout,
    input logic              cpu_doe,
    input logic              req_valid,
    input logic              req_ready,
    input logic              at_opc
);

    logic jmp_fetch;
    assign jmp_fetch = at_opc && cpu_rw && cpu_addr[ADDR_W-1]
                       && (cpu_addr[ADDR_W-2:0] >= JMP_AT);

    assert_no_drive_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rw |-> !cpu_doe);

    assert_no_drive_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[ADDR_W-1] |-> (!cpu_doe && cpu_dout == 8'h00));

    assert_jmp_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_fetch |-> (cpu_doe && cpu_dout == OPC_JMP_ABS));

    assert_jmp_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_fetch |=> (!cpu_doe || cpu_dout == JMP_TARGET[7:0]));

    assert_pop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_pop_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid);

    assert_pop_after_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ($past(cpu_doe) && $past(cpu_dout) == OPC_STA_ZP));

endmodule

bind instruction_feeder feeder_chk #(
    .ADDR_W     (ADDR_W),
    .JMP_AT     (JMP_AT),
    .JMP_TARGET (JMP_TARGET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rw    (cpu_rw),
    .cpu_dout  (cpu_dout),
    .cpu_doe   (cpu_doe),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .at_opc    (at_opc)
);

// File: tb/instruction_feeder_test.sv
module instruction_feeder_test;

    localparam int         CLK_PERIOD = 10;
    localparam logic [11:0] THR       = 12'h060;
    localparam int         QMAX       = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = 13'h1000;
    logic        rw = 1'b1;
    logic        rv = 1'b0, rs = 1'b0;
    logic [7:0]  rr = 8'h00, rvl = 8'h00;
    wire  [7:0]  dout;
    wire         doe;
    wire         rdy;

    always #(CLK_PERIOD/2) clk = ~clk;

    instruction_feeder #(.ADDR_W(13), .JMP_AT(THR), .JMP_TARGET(16'h1000)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_rw(rw),
        .cpu_dout(dout), .cpu_doe(doe),
        .req_valid(rv), .req_sync(rs), .req_reg(rr), .req_val(rvl),
        .req_ready(rdy)
    );

    int errors = 0, checks = 0;
    bit finished = 1'b0;

    logic       q_sync [QMAX];
    logic [7:0] q_reg  [QMAX];
    logic [7:0] q_val  [QMAX];
    int head = 0, tail = 0;

    logic [12:0] pc = 13'h1000;
    logic [7:0]  acc = 8'h00;
    bit lda_done = 1'b0;
    bit first_fetch = 1'b0;
    int jmp_mid_pair = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic update_req();
        rv  = (head < tail);
        rs  = (head < tail) ? q_sync[head] : 1'b0;
        rr  = (head < tail) ? q_reg[head]  : 8'h00;
        rvl = (head < tail) ? q_val[head]  : 8'h00;
    endtask

    task automatic push(input bit s, input logic [7:0] r, input logic [7:0] v);
        q_sync[tail] = s; q_reg[tail] = r; q_val[tail] = v;
        tail++;
        update_req();
    endtask

    task automatic bus(input logic [12:0] a, input bit w,
                       output logic [7:0] d, output bit oe, output bit rd);
        addr = a; rw = w;
        @(negedge clk);
        d = dout; oe = doe; rd = rdy;
        @(posedge clk); #1;
        if (rd && rv) head++;
        update_req();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; addr = 13'h1000; rw = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        pc = 13'h1000; lda_done = 1'b0; first_fetch = 1'b1;
    endtask

    // One CPU instruction, decoded by the bench's own CPU model
    task automatic step();
        logic [7:0] op, b1, b2, exp_op, exp_zp;
        bit oe, rd;
        int idx;
        string tag;
        if (pc[11:0] >= THR)       begin exp_op = 8'h4C; tag = "R5"; end
        else if (lda_done)         begin exp_op = 8'h85; tag = "R2"; end
        else if (head < tail)      begin exp_op = q_sync[head] ? 8'h85 : 8'hA9;
                                         tag = q_sync[head] ? "R3" : "R2"; end
        else                       begin exp_op = 8'hEA; tag = "R4"; end
        if (first_fetch) tag = "R1";
        chk(pc[11:0] <= THR + 12'd1, "R5 fetch offset bound", int'(pc[11:0]), int'(THR) + 1);
        bus(pc, 1'b1, op, oe, rd);
        chk(op == exp_op, {tag, " opcode"}, op, exp_op);
        chk(oe, "R7 drive on window read", oe, 1);
        chk(!rd, "R6 no pop on opcode", rd, 0);
        first_fetch = 1'b0;
        if (op == 8'h4C && lda_done) jmp_mid_pair++;
        case (op)
            8'hA9: begin
                idx = head;
                bus(pc + 13'd1, 1'b1, b1, oe, rd);
                chk(b1 == q_val[idx], "R2 load value", b1, q_val[idx]);
                chk(!rd, "R6 no pop on load", rd, 0);
                acc = b1; lda_done = 1'b1; pc = pc + 13'd2;
            end
            8'h85: begin
                idx = head;
                exp_zp = lda_done ? q_reg[idx] : 8'h02;
                bus(pc + 13'd1, 1'b1, b1, oe, rd);
                chk(b1 == exp_zp, lda_done ? "R2 store address" : "R3 sync address", b1, exp_zp);
                chk(rd, "R6 pop on store operand", rd, 1);
                bus({5'b0, b1}, 1'b0, b2, oe, rd);
                chk(!oe && b2 == 8'h00, "R7 store cycle undriven", oe, 0);
                if (lda_done) chk(acc == q_val[idx], "R2 stored value", acc, q_val[idx]);
                lda_done = 1'b0; pc = pc + 13'd2;
            end
            8'hEA: begin
                bus(pc + 13'd1, 1'b1, b1, oe, rd);
                chk(b1 == 8'hEA, "R4 dummy read byte", b1, 8'hEA);
                chk(!rd, "R4 dummy read pops nothing", rd, 0);
                pc = pc + 13'd1;
            end
            8'h4C: begin
                bus(pc + 13'd1, 1'b1, b1, oe, rd);
                bus(pc + 13'd2, 1'b1, b2, oe, rd);
                chk(b1 == 8'h00, "R5 jump low", b1, 8'h00);
                chk(b2 == 8'h10, "R5 jump high", b2, 8'h10);
                pc = {b2[4:0], b1};
            end
            default: begin
                chk(1'b0, "R2 unknown opcode", op, exp_op);
                pc = pc + 13'd1;
            end
        endcase
    endtask

    task automatic drain();
        while ((head < tail || lda_done) && !finished) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R6 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit oe, rd;
        update_req();
        do_reset();
        // R1 reset state
        chk(!rdy, "R1 ready after reset", rdy, 0);
        // R4 idle filler
        for (int i = 0; i < 10; i++) step();

        // R2 sweep of register addresses
        for (int r = 0; r < 64; r++) push(1'b0, 8'(r), 8'(r * 37 + 5));
        drain();
        // R2 sweep of every value into one register
        for (int v = 0; v < 256; v++) push(1'b0, 8'h1B, 8'(v));
        drain();
        // R3 mixed syncs and writes, R6 order
        for (int i = 0; i < 120; i++) begin
            if (i % 3 == 0) push(1'b1, 8'h00, 8'h00);
            else push(1'b0, 8'(8'h20 + i[4:0]), 8'(i ^ 8'h5A));
        end
        drain();
        // trickle: requests separated by idle filler
        for (int i = 0; i < 12; i++) begin
            push(i[0], 8'(8'h08 + i), 8'(8'hC0 + i));
            for (int k = 0; k < 3; k++) step();
        end
        drain();

        // R5 jump placed between a load and its store
        do_reset();
        while (pc[11:0] != THR - 12'd2) step();
        jmp_mid_pair = 0;
        push(1'b0, 8'h15, 8'h3C);
        drain();
        chk(jmp_mid_pair > 0, "R5 owed store after jump", jmp_mid_pair, 1);
        chk(pc[11:0] < 12'h010, "R5 store emitted after wrap", int'(pc[11:0]), 4);

        // R7 stray cycles
        do_reset();
        bus(13'h0080, 1'b1, d, oe, rd);
        chk(!oe && d == 8'h00, "R7 read outside window", oe, 0);
        bus(13'h1005, 1'b0, d, oe, rd);
        chk(!oe && d == 8'h00, "R7 write inside window", oe, 0);
        do_reset();
        step();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule